// File: doc/BRIEF.md
# Validated Receive Stream Output Buffer

This block sits between the receive path of one connection and the application that consumes its payload. Payload bytes arrive one per clock together with an end-of-frame marker and, on that last byte, a flag that says whether the whole frame passed its checks. Bytes are stored as they arrive, but they stay tentative. A good frame commits them. A bad frame rewinds the write pointer to the last commit point, so none of its bytes is ever delivered.

Committed bytes reach the application through a 64-bit output word that fills from the most significant byte down, with a byte mask beside it. The application watches a ready-to-send flag and answers with clear-to-send, either as single pulses or held high. A fetched word appears two clocks after the clear-to-send that the block accepted. A full word is shown for one clock only. A partial word stays on the output and keeps filling in place as later frames commit. Back-pressure on the input side is advisory: an almost-full flag tells the upstream path that one more maximum-size frame might not fit. A byte that still meets a full buffer is dropped, and the frame that carries it is discarded.

Top module: `rxv_stream_buf`

## Requirements
- R1: After reset, `rts`, `cts_ack` and `almost_full` are low, `out_mask` is 0x00 and `out_data` is zero.
- R2: Delivered bytes appear in arrival order. The first byte of a word sits in bits 63:56, and the mask is contiguous from bit 7 down (0x80 for one byte, 0xC0 for two, up to 0xFF). Byte lanes outside the mask read as zero.
- R3: A frame whose last byte carries `in_good`=0 is discarded. None of its bytes is ever delivered, and the bytes of the next good frame follow the bytes committed before it.
- R4: `rts` is high exactly when at least one committed byte is neither shown on the output word nor already taken into it.
- R5: A clear-to-send that is sampled while `rts` is high, no fetch is in flight and the output word is empty or full is accepted. `cts_ack` is high for one clock after that edge, and the fetched word is on the outputs after the next edge, two clocks after the request.
- R6: A clear-to-send that is sampled while `rts` is low is ignored. No `cts_ack` follows and the output word does not change.
- R7: A word with mask 0xFF stays on the outputs for exactly one clock. After that the mask returns to 0x00 unless a new fetch has landed.
- R8: A partial word (mask 0x80 to 0xFE) stays on the outputs. Bytes that commit later fill it in place toward the least significant lane, and bytes already shown keep their value and position.
- R9: The mask never grows while a frame is still arriving. It changes only after the validity of a frame is known.
- R10: `almost_full` is high exactly when free space, counting tentative bytes as used, is below `MAX_FRAME` bytes.
- R11: A byte that arrives while the buffer holds `2**ADDR_W` bytes is not stored, and the frame that carries it is discarded even when its end-of-frame flag says good.
- R12: With clear-to-send held high, committed data streams out as consecutive full words, one every two clocks, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A payload byte is present this clock |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | This byte ends the frame |
| in_good | input | 1 | Frame validity, read together with `in_last` |
| almost_full | output | 1 | Free space is below one maximum frame |
| rts | output | 1 | Committed bytes are waiting to be fetched |
| cts | input | 1 | Application requests the next word |
| cts_ack | output | 1 | The clear-to-send one clock earlier was accepted |
| out_data | output | 64 | Output word, first byte in bits 63:56 |
| out_mask | output | 8 | Valid lanes of `out_data`, bit 7 for the first lane |

## Verification
A good frame of exactly eight bytes is fetched with a single pulse. This separates the fetch latency, the byte order and the one-clock life of a full word. A three-byte frame followed by two-byte and four-byte frames builds a partial word that must hold, fill in place, turn full with one byte left over, and then show that byte alone. This tells in-place filling apart from replacement, and it shows that nothing moves while a frame is still arriving. A bad frame placed before a good one, and a frame offered to a full buffer, show that discarded bytes never leak into the stream. Continuous clear-to-send over several committed frames checks ordering and spacing across word boundaries. Filling the buffer to one byte past the threshold pins the almost-full point exactly.

// File: rtl/rxv_pkg.sv
package rxv_pkg;
  typedef logic [7:0] rxv_byte_t;

  function automatic int min_int(input int a, input int b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/rxv_store.sv
module rxv_store #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 8,
  parameter int CNT_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [7:0]            in_data,
  input  logic                  in_last,
  input  logic                  in_good,
  input  logic [CNT_W-1:0]      take,
  output logic [ADDR_W:0]       avail,
  output logic [ADDR_W:0]       occ,
  output logic [LANES*8-1:0]    win
);
  import rxv_pkg::*;
  localparam int DEPTH = 1 << ADDR_W;

  rxv_byte_t       mem [DEPTH];
  logic [ADDR_W:0] wr_q, cm_q, rd_q;
  logic            bad_q;
  logic            full;
  logic [ADDR_W:0] wr_adv;
  logic            drop;

  assign occ    = wr_q - rd_q;
  assign avail  = cm_q - rd_q;
  assign full   = (occ == (ADDR_W+1)'(DEPTH));
  assign wr_adv = full ? wr_q : wr_q + 1'b1;
  assign drop   = bad_q | full;

  always_ff @(posedge clk) begin
    if (in_valid && !full) mem[wr_q[ADDR_W-1:0]] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      cm_q  <= '0;
      rd_q  <= '0;
      bad_q <= 1'b0;
    end else begin
      rd_q <= rd_q + (ADDR_W+1)'(take);
      if (in_valid) begin
        if (in_last) begin
          if (in_good && !drop) begin
            cm_q <= wr_adv;
            wr_q <= wr_adv;
          end else begin
            wr_q <= cm_q;
          end
          bad_q <= 1'b0;
        end else begin
          wr_q  <= wr_adv;
          bad_q <= drop;
        end
      end
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_win
    logic [ADDR_W:0] pos;
    assign pos = rd_q + (ADDR_W+1)'(j);
    assign win[8*j +: 8] = mem[pos[ADDR_W-1:0]];
  end
endmodule

// File: rtl/rxv_word.sv
module rxv_word #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 8,
  parameter int CNT_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cts,
  input  logic [ADDR_W:0]       avail,
  input  logic [LANES*8-1:0]    win,
  output logic                  rts,
  output logic                  cts_ack,
  output logic [LANES*8-1:0]    out_data,
  output logic [LANES-1:0]      out_mask,
  output logic [CNT_W-1:0]      take
);
  import rxv_pkg::*;

  logic [CNT_W-1:0]   n_q;
  logic               pend_q;
  logic               acc;
  logic               move;
  int                 base;
  int                 k;
  logic [LANES*8-1:0] nd;

  assign rts = (avail != '0);
  assign acc = cts && rts && !pend_q &&
               ((n_q == '0) || (n_q == CNT_W'(LANES)));

  always_comb begin
    move = 1'b0;
    base = 0;
    if (pend_q) begin
      move = 1'b1;
    end else if ((n_q != '0) && (n_q != CNT_W'(LANES)) && rts) begin
      move = 1'b1;
      base = int'(n_q);
    end
    k    = move ? min_int(int'(avail), LANES - base) : 0;
    take = CNT_W'(k);
    nd   = pend_q ? '0 : out_data;
    for (int i = 0; i < LANES; i++) begin
      if (move && i >= base && i < base + k)
        nd[8*(LANES-1-i) +: 8] = win[8*(i-base) +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      n_q      <= '0;
      pend_q   <= 1'b0;
      cts_ack  <= 1'b0;
      out_data <= '0;
    end else begin
      pend_q  <= acc;
      cts_ack <= acc;
      if (move) begin
        n_q      <= pend_q ? CNT_W'(k) : n_q + CNT_W'(k);
        out_data <= nd;
      end else if (n_q == CNT_W'(LANES)) begin
        n_q      <= '0;
        out_data <= '0;
      end
    end
  end

  for (genvar b = 0; b < LANES; b++) begin : g_mask
    assign out_mask[LANES-1-b] = (n_q > CNT_W'(b));
  end
endmodule

// File: rtl/rxv_stream_buf.sv
module rxv_stream_buf #(
  parameter int ADDR_W    = 6,
  parameter int MAX_FRAME = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  input  logic        in_good,
  output logic        almost_full,
  output logic        rts,
  input  logic        cts,
  output logic        cts_ack,
  output logic [63:0] out_data,
  output logic [7:0]  out_mask
);
  localparam int LANES = 8;
  localparam int CNT_W = $clog2(LANES) + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic [CNT_W-1:0]   take;
  logic [ADDR_W:0]    avail;
  logic [ADDR_W:0]    occ;
  logic [LANES*8-1:0] win;
  logic [ADDR_W+1:0]  free_b;

  rxv_store #(.ADDR_W(ADDR_W), .LANES(LANES), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_good(in_good), .take(take),
    .avail(avail), .occ(occ), .win(win)
  );

  rxv_word #(.ADDR_W(ADDR_W), .LANES(LANES), .CNT_W(CNT_W)) u_word (
    .clk(clk), .rst(rst), .cts(cts), .avail(avail), .win(win),
    .rts(rts), .cts_ack(cts_ack), .out_data(out_data),
    .out_mask(out_mask), .take(take)
  );

  assign free_b      = (ADDR_W+2)'(DEPTH) - {1'b0, occ};
  assign almost_full = (free_b < (ADDR_W+2)'(MAX_FRAME));
endmodule

// File: rtl/rxv_chk.sv
module rxv_chk (
  input logic       clk,
  input logic       rst,
  input logic       cts,
  input logic       rts,
  input logic       cts_ack,
  input logic [7:0] out_mask
);
  // R5
  ack_then_word_chk: assert property (@(posedge clk) disable iff (rst)
    cts_ack |-> (out_mask == 8'h00 || out_mask == 8'hFF) ##1 (out_mask != 8'h00));

  // R6
  ack_needs_rts_chk: assert property (@(posedge clk) disable iff (rst)
    cts_ack |-> $past(rts) && $past(cts));

  // R7
  full_one_clock_chk: assert property (@(posedge clk) disable iff (rst)
    (out_mask == 8'hFF) |=> (out_mask == 8'h00));

  // R8
  partial_grows_chk: assert property (@(posedge clk) disable iff (rst)
    (out_mask != 8'h00 && out_mask != 8'hFF) |=>
      ((out_mask & $past(out_mask)) == $past(out_mask)));

  // R2
  mask_contig_chk: assert property (@(posedge clk) disable iff (rst)
    (({out_mask[6:0], 1'b0} & ~out_mask) == 8'h00));
endmodule

bind rxv_stream_buf rxv_chk u_chk (
  .clk(clk), .rst(rst), .cts(cts), .rts(rts),
  .cts_ack(cts_ack), .out_mask(out_mask)
);

// File: tb/sim_rxv_stream_buf.sv
module sim_rxv_stream_buf;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_last = 1'b0;
  logic        in_good = 1'b0;
  logic        cts = 1'b0;
  logic        almost_full, rts, cts_ack;
  logic [63:0] out_data;
  logic [7:0]  out_mask;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  rxv_stream_buf #(.ADDR_W(6), .MAX_FRAME(16)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_good(in_good), .almost_full(almost_full),
    .rts(rts), .cts(cts), .cts_ack(cts_ack),
    .out_data(out_data), .out_mask(out_mask)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; in_last = 1'b0; in_good = 1'b0; cts = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] d, input logic last, input logic good);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_last = last; in_good = good;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_good = 1'b0;
  endtask

  task automatic send_frame(input int n, input logic [7:0] base, input logic good);
    for (int i = 0; i < n; i++) put_byte(base + 8'(i), i == n-1, good);
    idle();
  endtask

  task automatic fetch(input string req);
    @(negedge clk); cts = 1'b1;
    @(negedge clk); cts = 1'b0;
    chk(req, 64'(cts_ack), 64'd1);
    @(negedge clk);
  endtask

  function automatic logic [63:0] seq_word(input logic [7:0] base);
    logic [63:0] w;
    for (int i = 0; i < 8; i++) w[8*(7-i) +: 8] = base + 8'(i);
    return w;
  endfunction

  task automatic stream(input string req, input int words, input logic [7:0] base);
    int got = 0;
    @(negedge clk); cts = 1'b1;
    for (int c = 0; c < 4*words + 6; c++) begin
      @(negedge clk);
      if (out_mask == 8'hFF) begin
        chk(req, out_data, seq_word(base + 8'(8*got)));
        got++;
      end
    end
    cts = 1'b0;
    chk(req, 64'(got), 64'(words));
    @(negedge clk);
    chk("R4 empty after drain", 64'(rts), 64'd0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 rts", 64'(rts), 64'd0);
    chk("R1 mask", 64'(out_mask), 64'd0);
    chk("R1 data", out_data, 64'd0);
    chk("R1 ack", 64'(cts_ack), 64'd0);
    chk("R1 almost_full", 64'(almost_full), 64'd0);
  endtask

  task automatic t_full_word();
    do_reset();
    send_frame(8, 8'h10, 1'b1);
    chk("R4 rts after commit", 64'(rts), 64'd1);
    chk("R5 no word before fetch", 64'(out_mask), 64'd0);
    fetch("R5 ack");
    chk("R5 mask after two clocks", 64'(out_mask), 64'hFF);
    chk("R2 byte order", out_data, 64'h1011121314151617);
    chk("R4 rts cleared", 64'(rts), 64'd0);
    @(negedge clk);
    chk("R7 full word one clock", 64'(out_mask), 64'd0);
  endtask

  task automatic t_partial();
    do_reset();
    send_frame(3, 8'hA0, 1'b1);
    fetch("R5 ack partial");
    chk("R2 partial mask", 64'(out_mask), 64'hE0);
    chk("R2 partial data", out_data, 64'hA0A1A20000000000);
    repeat (5) @(negedge clk);
    chk("R8 partial held", 64'(out_mask), 64'hE0);
    put_byte(8'hB0, 1'b0, 1'b1);
    put_byte(8'hB1, 1'b1, 1'b1);
    chk("R9 mask fixed mid frame", 64'(out_mask), 64'hE0);
    chk("R9 rts low mid frame", 64'(rts), 64'd0);
    idle();
    @(negedge clk);
    chk("R8 fill in place mask", 64'(out_mask), 64'hF8);
    chk("R8 fill in place data", out_data, 64'hA0A1A2B0B1000000);
    send_frame(4, 8'hC0, 1'b1);
    @(negedge clk);
    chk("R8 filled to full", 64'(out_mask), 64'hFF);
    chk("R8 full data", out_data, 64'hA0A1A2B0B1C0C1C2);
    chk("R4 leftover byte", 64'(rts), 64'd1);
    @(negedge clk);
    chk("R7 cleared", 64'(out_mask), 64'd0);
    fetch("R5 ack leftover");
    chk("R2 leftover", out_data, 64'hC300000000000000);
    chk("R2 leftover mask", 64'(out_mask), 64'h80);
  endtask

  task automatic t_discard();
    do_reset();
    send_frame(4, 8'hE0, 1'b0);
    chk("R3 bad frame not ready", 64'(rts), 64'd0);
    send_frame(2, 8'h55, 1'b1);
    fetch("R3 ack");
    chk("R3 good after bad", out_data, 64'h5556000000000000);
    chk("R3 mask", 64'(out_mask), 64'hC0);
  endtask

  task automatic t_ignore();
    do_reset();
    @(negedge clk); cts = 1'b1;
    @(negedge clk); cts = 1'b0;
    chk("R6 no ack", 64'(cts_ack), 64'd0);
    @(negedge clk);
    chk("R6 no word", 64'(out_mask), 64'd0);
    send_frame(1, 8'h77, 1'b1);
    fetch("R6 later fetch acked");
    chk("R6 later word", out_data, 64'h7700000000000000);
  endtask

  task automatic t_stream();
    do_reset();
    send_frame(16, 8'h20, 1'b1);
    send_frame(8, 8'h30, 1'b1);
    stream("R12 stream word", 3, 8'h20);
  endtask

  task automatic t_fill();
    do_reset();
    for (int f = 0; f < 3; f++) send_frame(16, 8'(16*f), 1'b1);
    chk("R10 at threshold", 64'(almost_full), 64'd0);
    send_frame(1, 8'h30, 1'b1);
    chk("R10 below threshold", 64'(almost_full), 64'd1);
    do_reset();
    for (int f = 0; f < 4; f++) send_frame(16, 8'(16*f), 1'b1);
    send_frame(3, 8'hF0, 1'b1);
    stream("R11 drain word", 8, 8'h00);
    send_frame(1, 8'h99, 1'b1);
    fetch("R11 ack after drain");
    chk("R11 no stray bytes", out_data, 64'h9900000000000000);
  endtask

  initial begin
    #(CLK_NS * 100000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_full_word();
    t_partial();
    t_discard();
    t_ignore();
    t_stream();
    t_fill();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule